// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block turns the two phase signals of an incremental encoder into a position value. A single counter can be switched at run time between four counting schemes: full quadrature with four counts per cycle, pulse with a separate direction level, fixed increment and fixed decrement. In the fixed schemes a resolution bit selects whether phase A counts on both of its edges or on rising edges only. Both encoder inputs are asynchronous. They pass through a synchroniser before any edge is taken from them.

Software reaches the block through a plain single-cycle register port with a byte address, write strobe, write data and combinational read data. The port gives access to the position, a ceiling, the decoder control and the counter control. Counting up past the ceiling wraps to zero, and counting down below zero wraps to the ceiling. A position write whose value is above the ceiling is dropped. In quadrature mode, a step in which both phases change at once does not move the count. It raises a one-cycle phase-error pulse.

Top module: `qpos_counter`

## Requirements
- R1: After reset the position reads 0, the ceiling reads all ones, the decoder control and counter control read 0, and `phase_err` is low.
- R2: In quadrature mode (mode code 0), every edge of A or B moves the count by one. The state order {A,B} = 00, 10, 11, 01, 00 counts up and the reverse order counts down. The new position is readable after the third rising clock edge that follows the input change, and not earlier.
- R3: In quadrature mode, a change of both A and B between two synchronised samples leaves the position unchanged and gives a one-cycle high on `phase_err`, due in the same cycle the position would have changed. Other modes never raise `phase_err`.
- R4: In pulse/direction mode (mode code 1), only a rising edge of A counts. It counts up when B is 1 and down when B is 0. Falling edges of A and all edges of B do not count.
- R5: In count-up mode (code 2) A edges increment, and in count-down mode (code 3) A edges decrement. Edges of B never count in either mode.
- R6: Bit 11 of the decoder control register selects the resolution. When it is 1, rising and falling edges of A both count in modes 2 and 3. When it is 0, only rising edges of A count.
- R7: Bit 3 of the counter control register (byte address 0x2A) enables counting. While it is 0 the position holds through any encoder activity.
- R8: An up count from a position equal to the ceiling gives 0. A down count from 0 gives the ceiling.
- R9: A position write (byte address 0x00) with a value not above the ceiling (byte address 0x08) loads that value, even when a count falls in the same cycle. A write with a value above the ceiling leaves the position unchanged.
- R10: The mode code is held in bits 15:14 of the decoder control register at byte address 0x28. Reads of 0x28 return only bits 15:14 and 11, and reads of 0x2A return only bit 3. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | POS_W | Write data |
| bus_rdata | output | POS_W | Read data for `bus_addr`, combinational |
| phase_err | output | 1 | One-cycle pulse on an illegal quadrature step |

## Verification
An encoder change passes two synchroniser flops and is compared with the previous sample. The position and `phase_err` therefore update on the third rising edge after the change. The bench waits exactly three edges after every encoder stimulus and samples one time unit later. In one case it also confirms that the position has not moved after only two edges. A register write takes effect on the edge that follows the strobe, and reads are combinational, so the bench checks each register a moment after driving the address. The same-cycle priority check places the write strobe on the third edge after an A rise, so the write and the count land on the same edge.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_PDIR = 2'd1,
    MODE_UP   = 2'd2,
    MODE_DOWN = 2'd3
  } cnt_mode_e;

  localparam logic [7:0] ADDR_POS = 8'h00;
  localparam logic [7:0] ADDR_MAX = 8'h08;
  localparam logic [7:0] ADDR_DEC = 8'h28;
  localparam logic [7:0] ADDR_CTL = 8'h2A;

  localparam int MODE_HI = 15;
  localparam int MODE_LO = 14;
  localparam int RES_BIT = 11;
  localparam int EN_BIT  = 3;
endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  logic [1:0] prev_ab,
  input  logic [1:0] cur_ab,
  input  cnt_mode_e  mode,
  input  logic       res_both,
  output logic       step_up,
  output logic       step_dn,
  output logic       pe
);
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   gray_pos = 2'd0;
      2'b10:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction

  logic       a_rise, a_fall;
  logic [1:0] delta;

  assign a_rise = cur_ab[1] & ~prev_ab[1];
  assign a_fall = ~cur_ab[1] & prev_ab[1];
  assign delta  = gray_pos(cur_ab) - gray_pos(prev_ab);

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    pe      = 1'b0;
    case (mode)
      MODE_QUAD: begin
        step_up = (delta == 2'd1);
        step_dn = (delta == 2'd3);
        pe      = (delta == 2'd2);
      end
      MODE_PDIR: begin
        step_up = a_rise & cur_ab[0];
        step_dn = a_rise & ~cur_ab[0];
      end
      MODE_UP:   step_up = a_rise | (res_both & a_fall);
      default:   step_dn = a_rise | (res_both & a_fall);
    endcase
  end
endmodule

// File: rtl/qpos_accum.sv
module qpos_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         wr_pos,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] max_val,
  output logic [W-1:0] pos
);
  localparam logic [W-1:0] ONE = W'(1);

  logic wr_ok;
  assign wr_ok = wr_pos && (wr_val <= max_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pos <= '0;
    else if (wr_ok)            pos <= wr_val;
    else if (en && step_up)    pos <= (pos == max_val) ? '0 : pos + ONE;
    else if (en && step_dn)    pos <= (pos == '0) ? max_val : pos - ONE;
  end
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [POS_W-1:0]  bus_wdata,
  output logic [POS_W-1:0]  bus_rdata,
  output logic              phase_err
);
  localparam logic [ADDR_W-1:0] A_POS = ADDR_W'(ADDR_POS);
  localparam logic [ADDR_W-1:0] A_MAX = ADDR_W'(ADDR_MAX);
  localparam logic [ADDR_W-1:0] A_DEC = ADDR_W'(ADDR_DEC);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTL);
  localparam int PAD16 = POS_W - 16;
  localparam int PAD4  = POS_W - 4;

  cnt_mode_e        mode_q;
  logic             res_q, en_q;
  logic [POS_W-1:0] max_q, pos_q;
  logic [1:0]       ab_sync, ab_prev;
  logic             step_up, step_dn, pe_raw, pos_wr;

  qpos_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({enc_a, enc_b}), .dout(ab_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_prev   <= 2'b00;
      phase_err <= 1'b0;
    end else begin
      ab_prev   <= ab_sync;
      phase_err <= pe_raw;
    end
  end

  qpos_decode u_dec (
    .prev_ab(ab_prev), .cur_ab(ab_sync), .mode(mode_q), .res_both(res_q),
    .step_up(step_up), .step_dn(step_dn), .pe(pe_raw)
  );

  assign pos_wr = bus_wr && (bus_addr == A_POS);

  qpos_accum #(.W(POS_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en_q), .step_up(step_up), .step_dn(step_dn),
    .wr_pos(pos_wr), .wr_val(bus_wdata), .max_val(max_q), .pos(pos_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_QUAD;
      res_q  <= 1'b0;
      en_q   <= 1'b0;
      max_q  <= '1;
    end else if (bus_wr) begin
      if (bus_addr == A_MAX) max_q <= bus_wdata;
      if (bus_addr == A_DEC) begin
        mode_q <= cnt_mode_e'(bus_wdata[MODE_HI:MODE_LO]);
        res_q  <= bus_wdata[RES_BIT];
      end
      if (bus_addr == A_CTL) en_q <= bus_wdata[EN_BIT];
    end
  end

  always_comb begin
    case (bus_addr)
      A_POS:   bus_rdata = pos_q;
      A_MAX:   bus_rdata = max_q;
      A_DEC:   bus_rdata = {{PAD16{1'b0}}, mode_q, 2'b00, res_q, 11'b0};
      A_CTL:   bus_rdata = {{PAD4{1'b0}}, en_q, 3'b000};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qpos_checker.sv
module qpos_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [1:0]   mode,
  input logic         pos_wr,
  input logic [W-1:0] wr_val,
  input logic [W-1:0] max_val,
  input logic [W-1:0] pos,
  input logic         step_up,
  input logic         step_dn,
  input logic         pe
);
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pos_wr) |=> $stable(pos));

  assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_wr && wr_val <= max_val) |=> (pos == $past(wr_val)));

  assert_write_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_wr && wr_val > max_val && !en) |=> $stable(pos));

  assert_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step_up && !pos_wr && pos == max_val) |=> (pos == '0));

  assert_wrap_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step_dn && !pos_wr && pos == '0) |=> (pos == $past(max_val)));

  assert_pe_quad_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pe |-> (mode == 2'd0));

  assert_one_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  assert_up_mode_no_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> !step_dn);

  assert_down_mode_no_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !step_up);
endmodule

bind qpos_counter qpos_checker #(.W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .pos_wr(pos_wr),
  .wr_val(bus_wdata), .max_val(max_q), .pos(pos_q),
  .step_up(step_up), .step_dn(step_dn), .pe(pe_raw)
);

// File: tb/tb_qpos_counter.sv
module tb_qpos_counter;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, enc_a = 1'b0, enc_b = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic phase_err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qpos_counter dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .phase_err(phase_err)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic set_ab(input logic a, input logic b, output logic pe);
    enc_a = a; enc_b = b;
    repeat (3) @(posedge clk);
    #1 pe = phase_err;
  endtask

  function automatic logic [1:0] ab_of(input int i);
    case (i)
      0: ab_of = 2'b00;
      1: ab_of = 2'b10;
      2: ab_of = 2'b11;
      default: ab_of = 2'b01;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic pe;
    int base;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(8'h00, v); chk("R1 pos", v, 0);
    rd(8'h08, v); chk("R1 max", v, '1);
    rd(8'h28, v); chk("R1 dec", v, 0);
    rd(8'h2A, v); chk("R1 ctl", v, 0);
    chk("R1 phase_err", {31'b0, phase_err}, 0);

    // R10 register map readback
    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, v); chk("R10 dec bits", v, 32'h0000_C800);
    wr(8'h2A, 32'hFFFF_FFFF); rd(8'h2A, v); chk("R10 ctl bits", v, 32'h0000_0008);
    wr(8'h28, 32'h0000_0000);
    wr(8'h08, 100);

    // R2 latency: A rise from 00 in quad mode
    wr(8'h00, 50);
    enc_a = 1'b1;
    repeat (2) @(posedge clk); #1;
    rd(8'h00, v); chk("R2 not before third edge", v, 50);
    @(posedge clk); #1;
    rd(8'h00, v); chk("R2 after third edge", v, 51);

    // R2/R3 sweep over all previous/current quadrature states
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 4; c++) begin
        int d;
        logic [1:0] s;
        s = ab_of(p); set_ab(s[1], s[0], pe);
        wr(8'h00, 50);
        s = ab_of(c); set_ab(s[1], s[0], pe);
        d = (c - p + 4) % 4;
        base = (d == 1) ? 51 : (d == 3) ? 49 : 50;
        rd(8'h00, v); chk("R2 quad step", v, W'(base));
        chk("R3 phase error flag", {31'b0, pe}, {31'b0, d == 2});
      end
    end

    // R4 pulse/direction
    wr(8'h28, 32'h4000);
    for (int b = 0; b < 2; b++) begin
      set_ab(1'b0, b[0], pe);
      wr(8'h00, 50);
      base = b ? 51 : 49;
      set_ab(1'b1, b[0], pe);  rd(8'h00, v); chk("R4 A rise counts by B", v, W'(base));
      chk("R3 no flag outside quad", {31'b0, pe}, 0);
      set_ab(1'b1, ~b[0], pe); rd(8'h00, v); chk("R4 B edge ignored", v, W'(base));
      set_ab(1'b0, ~b[0], pe); rd(8'h00, v); chk("R4 A fall ignored", v, W'(base));
    end

    // R5/R6 fixed up/down with both resolutions
    for (int m = 2; m < 4; m++) begin
      for (int x = 0; x < 2; x++) begin
        int s1;
        wr(8'h28, W'((m << 14) | (x << 11)));
        s1 = (m == 2) ? 1 : -1;
        set_ab(1'b0, 1'b0, pe);
        wr(8'h00, 50);
        set_ab(1'b1, 1'b0, pe); rd(8'h00, v); chk("R5 A rise", v, W'(50 + s1));
        set_ab(1'b1, 1'b1, pe); rd(8'h00, v); chk("R5 B ignored", v, W'(50 + s1));
        set_ab(1'b0, 1'b1, pe); rd(8'h00, v);
        chk("R6 A fall per resolution", v, W'(50 + s1 + (x ? s1 : 0)));
        set_ab(1'b0, 1'b0, pe); rd(8'h00, v);
        chk("R5 B fall ignored", v, W'(50 + s1 + (x ? s1 : 0)));
      end
    end

    // R7 enable clear holds
    wr(8'h28, 32'h8000);
    wr(8'h00, 40);
    wr(8'h2A, 0);
    set_ab(1'b1, 1'b0, pe); set_ab(1'b0, 1'b0, pe);
    rd(8'h00, v); chk("R7 hold while disabled", v, 40);
    wr(8'h2A, 8);

    // R8 wrap at ceiling and at zero
    wr(8'h08, 5);
    wr(8'h00, 5);
    set_ab(1'b1, 1'b0, pe); rd(8'h00, v); chk("R8 wrap up to zero", v, 0);
    wr(8'h28, 32'hC000);
    set_ab(1'b0, 1'b0, pe);
    set_ab(1'b1, 1'b0, pe); rd(8'h00, v); chk("R8 wrap down to ceiling", v, 5);

    // R9 refused and accepted writes
    wr(8'h00, 6); rd(8'h00, v); chk("R9 write above ceiling refused", v, 5);
    wr(8'h00, 3); rd(8'h00, v); chk("R9 write at or below ceiling", v, 3);

    // R9 write beats same-cycle count
    wr(8'h28, 32'h8000);
    set_ab(1'b0, 1'b0, pe);
    enc_a = 1'b1;
    repeat (2) @(posedge clk); #1;
    wr(8'h00, 2);
    rd(8'h00, v); chk("R9 write wins over count", v, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule